// File: doc/BRIEF.md
# SPI Master Serial Clock and Select Timing Generator

This block generates the serial clock, the active-low slave select and the per-edge shift and sample strobes for an SPI-style master. A 16-bit configuration word sets three things. The first is a 10-bit half-period divisor. The second is the number of half SCK periods between select assertion and the first clock edge. The third is the number of half SCK periods between the last clock edge and select release. The shift registers attached to the block use the strobes to move data. The block generates no data itself.

A transfer begins with a one-cycle start pulse, taken only while master mode is enabled and the block is idle. When the transfer starts, the configuration and the requested length of 8 or 16 bits are captured. The configuration register can then be rewritten at any time without disturbing the transfer that is running.

Top module: `spi_sck_timing`

## Requirements
- R1: After reset, `cfg_o` reads 0x5002: divisor 2, lead code 01 and lag code 01. SCK is low, select is high and busy is low.
- R2: One half SCK period lasts H input clocks, with H = divisor (bits 9:0) and a divisor of 0 treated as 1. Every SCK edge comes exactly H clocks after the previous one.
- R3: The lead code (bits 13:12) maps 00→1, 01→1, 10→2 and 11→3 half periods. The first SCK rise is seen that many times H clocks after select goes low.
- R4: The lag code (bits 15:14) uses the same mapping. Select returns high that many times H clocks after the last SCK fall.
- R5: With `len16_i` = 0 a transfer has 8 SCK pulses. With `len16_i` = 1 it has 16.
- R6: `sample_o` is a one-cycle pulse in each cycle in which SCK has just risen. `shift_o` is a one-cycle pulse in each cycle in which SCK has just fallen. Neither strobe fires at any other time.
- R7: Select goes low in the first cycle after an accepted start. `busy_o` is high exactly while select is low.
- R8: A start pulse received while busy has no effect. The running transfer keeps its timing and no second transfer follows it.
- R9: The configuration is captured at start. A write during a transfer updates `cfg_o` but not the timing of that transfer.
- R10: While `master_i` is low, start pulses are ignored and select stays high.
- R11: SCK is low whenever the block is not busy, and SCK is never high while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write enable |
| cfg_wdata_i | input | 16 | Configuration word write data |
| cfg_o | output | 16 | Current configuration word |
| master_i | input | 1 | Master mode enable |
| start_i | input | 1 | Transfer start pulse |
| len16_i | input | 1 | Transfer length select: 0 = 8 bits, 1 = 16 bits |
| sck_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Slave select, active low |
| busy_o | output | 1 | Transfer in progress |
| sample_o | output | 1 | Strobe in the cycle after an SCK rise |
| shift_o | output | 1 | Strobe in the cycle after an SCK fall |

## Verification
Four properties are checked on every cycle by the assertions:
- each strobe is tied to the matching SCK transition;
- busy tracks select;
- SCK stays low outside a transfer and never runs while select is high;
- an idle block only leaves idle after a start that is accepted in master mode.

The exact clock counts can only be shown by the bench scenarios. These counts are the half-period length for each divisor (including 0 and 1023), the lead and lag delays for all four codes, and the pulse count for both lengths. The bench also shows that a configuration write or a second start pulse in the middle of a transfer leaves that transfer's timing unchanged.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CLK,
    ST_LAG
  } spt_state_e;

  localparam logic [15:0] CFG_RST = 16'h5002;

  // delay code -> half SCK periods: 00,01 -> 1; 10 -> 2; 11 -> 3
  function automatic logic [1:0] spt_halves(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/spt_cfg_reg.sv
module spt_cfg_reg #(
  parameter int unsigned CFG_W = 16,
  parameter logic [CFG_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/spt_half_div.sv
module spt_half_div #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] tmr_q;
  logic             wrap;

  assign wrap   = (tmr_q == half_i - DIV_W'(1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (!run_i || wrap)    tmr_q <= '0;
    else                        tmr_q <= tmr_q + DIV_W'(1);
  end
endmodule

// File: rtl/spt_seq.sv
module spt_seq
  import spt_pkg::*;
#(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned LONG_N  = 16,
  parameter int unsigned SHORT_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             master_i,
  input  logic             len16_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [1:0]       cfg_lead_i,
  input  logic [1:0]       cfg_lag_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [DIV_W-1:0] half_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             busy_o,
  output logic             sample_o,
  output logic             shift_o
);
  localparam int unsigned EDGE_W = $clog2(2 * LONG_N + 1);

  spt_state_e        state_q;
  logic [DIV_W-1:0]  half_q;
  logic [1:0]        lead_q, lag_q, hcnt_q;
  logic [EDGE_W-1:0] edges_q, ecnt_q;

  assign run_o  = (state_q != ST_IDLE);
  assign busy_o = run_o;
  assign half_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      half_q   <= DIV_W'(1);
      lead_q   <= 2'd1;
      lag_q    <= 2'd1;
      hcnt_q   <= '0;
      edges_q  <= EDGE_W'(2 * SHORT_N);
      ecnt_q   <= '0;
      sck_o    <= 1'b0;
      cs_no    <= 1'b1;
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
    end else begin
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && master_i) begin
            state_q <= ST_LEAD;
            cs_no   <= 1'b0;
            half_q  <= (cfg_div_i == '0) ? DIV_W'(1) : cfg_div_i;
            lead_q  <= spt_halves(cfg_lead_i);
            lag_q   <= spt_halves(cfg_lag_i);
            edges_q <= len16_i ? EDGE_W'(2 * LONG_N) : EDGE_W'(2 * SHORT_N);
            hcnt_q  <= '0;
          end
        end
        ST_LEAD: begin
          if (tick_i) begin
            if (hcnt_q == lead_q - 2'd1) begin
              state_q  <= ST_CLK;
              sck_o    <= 1'b1;
              sample_o <= 1'b1;
              ecnt_q   <= EDGE_W'(1);
            end else begin
              hcnt_q <= hcnt_q + 2'd1;
            end
          end
        end
        ST_CLK: begin
          if (tick_i) begin
            sck_o  <= ~sck_o;
            ecnt_q <= ecnt_q + EDGE_W'(1);
            if (sck_o) shift_o  <= 1'b1;
            else       sample_o <= 1'b1;
            if (ecnt_q == edges_q - EDGE_W'(1)) begin
              state_q <= ST_LAG;
              hcnt_q  <= '0;
            end
          end
        end
        ST_LAG: begin
          if (tick_i) begin
            if (hcnt_q == lag_q - 2'd1) begin
              state_q <= ST_IDLE;
              cs_no   <= 1'b1;
            end else begin
              hcnt_q <= hcnt_q + 2'd1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_timing.sv
module spi_sck_timing
  import spt_pkg::*;
#(
  parameter int unsigned DIV_W   = 10,
  parameter int unsigned LONG_N  = 16,
  parameter int unsigned SHORT_N = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_o,
  input  logic        master_i,
  input  logic        start_i,
  input  logic        len16_i,
  output logic        sck_o,
  output logic        cs_no,
  output logic        busy_o,
  output logic        sample_o,
  output logic        shift_o
);
  localparam int unsigned LEAD_LSB = DIV_W + 2;
  localparam int unsigned LAG_LSB  = DIV_W + 4;

  logic             run, tick;
  logic [DIV_W-1:0] half;

  spt_cfg_reg #(.CFG_W(16), .RST_VAL(CFG_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (cfg_o)
  );

  spt_half_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .half_i (half),
    .tick_o (tick)
  );

  spt_seq #(.DIV_W(DIV_W), .LONG_N(LONG_N), .SHORT_N(SHORT_N)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .master_i   (master_i),
    .len16_i    (len16_i),
    .cfg_div_i  (cfg_o[DIV_W-1:0]),
    .cfg_lead_i (cfg_o[LEAD_LSB+1:LEAD_LSB]),
    .cfg_lag_i  (cfg_o[LAG_LSB+1:LAG_LSB]),
    .tick_i     (tick),
    .run_o      (run),
    .half_o     (half),
    .sck_o      (sck_o),
    .cs_no      (cs_no),
    .busy_o     (busy_o),
    .sample_o   (sample_o),
    .shift_o    (shift_o)
  );
endmodule

// File: rtl/spt_checker.sv
module spt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic start_i,
  input logic sck_o,
  input logic cs_no,
  input logic busy_o,
  input logic sample_o,
  input logic shift_o
);
  AST_BUSY_IS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no);                                             // R7
  AST_SAMPLE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o == $rose(sck_o));                                     // R6
  AST_SHIFT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o == $fell(sck_o));                                      // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_o);                                           // R11
  AST_SCK_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);                                             // R11
  AST_NO_START_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(start_i && master_i)) |=> !busy_o);              // R10
  AST_START_SELECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && master_i) |=> !cs_no);                  // R7
endmodule

bind spi_sck_timing spt_checker u_spt_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (master_i),
  .start_i  (start_i),
  .sck_o    (sck_o),
  .cs_no    (cs_no),
  .busy_o   (busy_o),
  .sample_o (sample_o),
  .shift_o  (shift_o)
);

// File: tb/spi_sck_timing_bench.sv
module spi_sck_timing_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_o;
  logic        master_i = 1'b1;
  logic        start_i = 1'b0;
  logic        len16_i = 1'b0;
  logic        sck_o, cs_no, busy_o, sample_o, shift_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  spi_sck_timing u_spi_sck_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_o(cfg_o), .master_i(master_i), .start_i(start_i), .len16_i(len16_i),
    .sck_o(sck_o), .cs_no(cs_no), .busy_o(busy_o), .sample_o(sample_o), .shift_o(shift_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int halves(input int code);
    return (code == 0) ? 1 : code;
  endfunction

  task automatic write_cfg(input int dv, input int ld, input int lg);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = {2'(lg), 2'(ld), 2'b00, 10'(dv)};
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  // pert: 0 none, 1 start pulse mid-transfer, 2 cfg write mid-transfer
  task automatic run(input int dv, input int ld, input int lg, input bit l16, input int pert);
    int h, nl, ng, bits, t, first_rise, rises, falls, last_edge, sp_err, st_err, bz_err, end_t;
    logic prev;
    h = (dv == 0) ? 1 : dv;
    nl = halves(ld);
    ng = halves(lg);
    bits = l16 ? 16 : 8;
    first_rise = -1; rises = 0; falls = 0; last_edge = -1;
    sp_err = 0; st_err = 0; bz_err = 0; end_t = -1; prev = 1'b0;
    @(negedge clk_i);
    len16_i = l16;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cs_no == 1'b0, "R7 select low after start", int'(cs_no), 0);
    for (t = 0; t < 90000; t++) begin
      if (cs_no) begin
        end_t = t;
        break;
      end
      if (sck_o != prev) begin
        if (last_edge >= 0 && (t - last_edge) != h) sp_err++;
        if (sck_o) begin
          rises++;
          if (first_rise < 0) first_rise = t;
        end else falls++;
        last_edge = t;
      end
      if (sample_o != (sck_o && !prev)) st_err++;
      if (shift_o != (!sck_o && prev)) st_err++;
      if (busy_o != !cs_no) bz_err++;
      prev = sck_o;
      if (t == 3 && pert == 1) start_i = 1'b1;
      if (t == 3 && pert == 2) begin
        cfg_we_i = 1'b1;
        cfg_wdata_i = 16'h0000;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      cfg_we_i = 1'b0;
    end
    chk(first_rise == nl * h, "R3 lead delay", first_rise, nl * h);
    chk(last_edge == (nl + 2 * bits - 1) * h, "R2 last SCK fall time", last_edge, (nl + 2 * bits - 1) * h);
    chk(sp_err == 0, "R2 half period spacing", sp_err, 0);
    chk(rises == bits && falls == bits, "R5 pulse count", rises, bits);
    chk(st_err == 0, "R6 strobe alignment", st_err, 0);
    chk(bz_err == 0 && !busy_o, "R7 busy vs select", bz_err, 0);
    chk(end_t == (nl + 2 * bits - 1 + ng) * h, "R4 lag delay", end_t, (nl + 2 * bits - 1 + ng) * h);
    chk(!sck_o, "R11 SCK low when idle", int'(sck_o), 0);
    if (pert == 1) begin
      repeat (4) @(negedge clk_i);
      chk(cs_no && !busy_o, "R8 no retrigger", int'(busy_o), 0);
    end
    if (pert == 2) begin
      chk(cfg_o == 16'h0000, "R9 cfg_o shows write", int'(cfg_o), 0);
      chk(end_t == (nl + 2 * bits - 1 + ng) * h, "R9 timing kept", end_t, (nl + 2 * bits - 1 + ng) * h);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cfg_o == 16'h5002, "R1 reset config", int'(cfg_o), 32'h5002);
    chk(!sck_o && cs_no && !busy_o && !sample_o && !shift_o, "R1 idle outputs", int'(busy_o), 0);
    // R1: default config transfer, H=2, lead/lag one half period
    run(2, 1, 1, 1'b0, 0);
    // R10: master disabled
    master_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (8) begin
      chk(cs_no && !busy_o && !sck_o, "R10 start ignored in non-master", int'(cs_no), 1);
      @(negedge clk_i);
    end
    master_i = 1'b1;
    for (int dv = 0; dv < 4; dv++)
      for (int ld = 0; ld < 4; ld++)
        for (int lg = 0; lg < 4; lg++)
          for (int l = 0; l < 2; l++) begin
            write_cfg(dv, ld, lg);
            run(dv, ld, lg, l[0], (ld + lg + dv) % 3);
          end
    // R2: largest divisor
    write_cfg(1023, 3, 2);
    run(1023, 3, 2, 1'b0, 2);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule